// File: doc/BRIEF.md
# Shift, Rotate and Normalize Unit

This block is the 16-bit shifting stage of a processor datapath. For each request it applies one of five shift or rotate operations to a word operand, or it computes a normalize count: the number of left shifts that would move the leading 1 of the operand up to bit 15. The shift distance is 4 bits wide. It comes either from an immediate field or from the low four bits of a register value. The operation code picks which one of these applies.

Each request is a single-cycle strobe. The result and four condition flags (zero, negative, carry, overflow) are computed combinationally. They are captured in output registers on that edge and are presented with a valid pulse on the following cycle. They then hold until the next request. Shifts that span more than one word and distances above 15 are outside this block.

Top module: `shift_norm_unit`

## Requirements
- R1: Operation code 0 is a logical left shift: zeros enter at bit 0, and carry is the last bit shifted out of bit 15 (operand bit 16-n).
- R2: Operation code 1 is a logical right shift: zeros enter at bit 15, and carry is the last bit shifted out of bit 0 (operand bit n-1).
- R3: Operation codes 2 and 3 rotate left and right. No bit is lost. Carry is the last bit carried around, which equals result bit 0 for a left rotate and result bit 15 for a right rotate.
- R4: Operation code 4 is an arithmetic right shift: copies of operand bit 15 fill the vacated top bits, and carry is operand bit n-1.
- R5: Overflow is set for a left shift when any bit shifted out differs from result bit 15. It is set for an arithmetic right shift when any shifted-out bit is 1. It is 0 for codes 1, 2, 3 and 5.
- R6: Operation code 5 returns, zero-extended, the number of left shifts that bring the highest set bit to bit 15. An all-zero operand returns 0. Carry and overflow are 0.
- R7: A shift distance of 0 with any of codes 0 to 4 returns the operand unchanged, with carry and overflow both 0.
- R8: When the count-source select is 1, the distance is bits 3:0 of the register count input and its upper bits have no effect. When the select is 0, the distance is the immediate input.
- R9: Zero is 1 exactly when the 16-bit result is all zeros. Negative equals result bit 15, for every operation.
- R10: Valid is 1 in the cycle after a request strobe and 0 otherwise. Result and flags hold their values in cycles with no request.
- R11: After reset, valid, result and all four flags are 0.
- R12: Operation codes 6 and 7 pass the operand through unchanged, with carry and overflow both 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Request strobe, one cycle per operation |
| op_i | input | 3 | Operation code (0 SHL, 1 SHR, 2 ROL, 3 ROR, 4 ASR, 5 normalize) |
| cnt_from_reg_i | input | 1 | 1: distance from register count, 0: from immediate |
| imm_cnt_i | input | 4 | Immediate shift distance |
| reg_cnt_i | input | 16 | Register value whose low 4 bits give the distance |
| operand_i | input | 16 | Word to be shifted or normalized |
| result_o | output | 16 | Registered result |
| zero_o | output | 1 | Result is zero |
| neg_o | output | 1 | Result bit 15 |
| carry_o | output | 1 | Last bit shifted or rotated out |
| ovf_o | output | 1 | Overflow as defined in R5 |
| valid_o | output | 1 | Result and flags updated this cycle |

## Verification
Every operation code is swept across all sixteen distances with four operands. The sign-set alternating pattern distinguishes sign fill from zero fill, and the single-bit word exposes an off-by-one in the carry index. The nearly all-ones word separates the left-shift overflow case where bits match the sign from the case where they do not, and the all-ones word does the same for the arithmetic-right overflow. Directed words check that overflow turns on exactly when the sign changes, that the normalize count is correct at both ends and for zero, and that a register count with garbage upper bits gives the same answer as an immediate. Random requests issued back to back and interleaved with idle cycles check the hold behaviour against the model.

// File: rtl/shift_norm_pkg.sv
package shift_norm_pkg;

  typedef enum logic [2:0] {
    OP_SHL  = 3'd0,
    OP_SHR  = 3'd1,
    OP_ROL  = 3'd2,
    OP_ROR  = 3'd3,
    OP_ASR  = 3'd4,
    OP_NORM = 3'd5,
    OP_RSV6 = 3'd6,
    OP_RSV7 = 3'd7
  } sh_op_e;

  typedef struct packed {
    logic z;
    logic n;
    logic c;
    logic v;
  } sh_flags_t;

endpackage

// File: rtl/shift_norm_cnt_sel.sv
module shift_norm_cnt_sel #(
  parameter int WIDTH = 16,
  parameter int CW    = $clog2(WIDTH)
) (
  input  logic             use_reg_i,
  input  logic [CW-1:0]    imm_i,
  input  logic [WIDTH-1:0] reg_i,
  output logic [CW-1:0]    cnt_o
);

  // Upper register bits carry no distance information.
  logic unused_reg_hi;
  assign unused_reg_hi = ^reg_i[WIDTH-1:CW];

  assign cnt_o = use_reg_i ? reg_i[CW-1:0] : imm_i;

endmodule

// File: rtl/shift_norm_lead.sv
module shift_norm_lead #(
  parameter int WIDTH = 16,
  parameter int CW    = $clog2(WIDTH)
) (
  input  logic [WIDTH-1:0] a_i,
  output logic [CW-1:0]    cnt_o
);

  // Highest set bit wins; an all-zero word leaves the count at 0.
  always_comb begin
    cnt_o = '0;
    for (int i = 0; i < WIDTH; i++) begin
      if (a_i[i]) cnt_o = CW'(WIDTH - 1 - i);
    end
  end

endmodule

// File: rtl/shift_norm_core.sv
module shift_norm_core
  import shift_norm_pkg::*;
#(
  parameter int WIDTH = 16,
  parameter int CW    = $clog2(WIDTH)
) (
  input  sh_op_e           op_i,
  input  logic [CW-1:0]    cnt_i,
  input  logic [WIDTH-1:0] a_i,
  input  logic [CW-1:0]    norm_i,
  output logic [WIDTH-1:0] res_o,
  output sh_flags_t        flags_o
);

  logic [2*WIDTH-1:0] dbl_l, dbl_r;
  logic [WIDTH:0]     ext_l, ext_r;
  logic [WIDTH-1:0]   shl, shr, asr, rotl, rotr;
  logic [WIDTH-1:0]   out_mask_l, out_mask_r;
  logic               nz;

  assign nz         = |cnt_i;
  assign dbl_l      = {a_i, a_i} << cnt_i;
  assign dbl_r      = {a_i, a_i} >> cnt_i;
  assign rotl       = dbl_l[2*WIDTH-1:WIDTH];
  assign rotr       = dbl_r[WIDTH-1:0];
  assign ext_l      = {1'b0, a_i} << cnt_i;
  assign ext_r      = {a_i, 1'b0} >> cnt_i;
  assign shl        = a_i << cnt_i;
  assign shr        = a_i >> cnt_i;
  assign asr        = WIDTH'($signed(a_i) >>> cnt_i);
  assign out_mask_l = ~({WIDTH{1'b1}} >> cnt_i);
  assign out_mask_r = ~({WIDTH{1'b1}} << cnt_i);

  always_comb begin
    res_o     = a_i;
    flags_o.c = 1'b0;
    flags_o.v = 1'b0;
    unique case (op_i)
      OP_SHL: begin
        res_o     = shl;
        flags_o.c = nz & ext_l[WIDTH];
        flags_o.v = |(out_mask_l & (a_i ^ {WIDTH{shl[WIDTH-1]}}));
      end
      OP_SHR: begin
        res_o     = shr;
        flags_o.c = nz & ext_r[0];
      end
      OP_ROL: begin
        res_o     = rotl;
        flags_o.c = nz & ext_l[WIDTH];
      end
      OP_ROR: begin
        res_o     = rotr;
        flags_o.c = nz & ext_r[0];
      end
      OP_ASR: begin
        res_o     = asr;
        flags_o.c = nz & ext_r[0];
        flags_o.v = |(out_mask_r & a_i);
      end
      OP_NORM: res_o = WIDTH'(norm_i);
      default: res_o = a_i;
    endcase
    flags_o.z = ~|res_o;
    flags_o.n = res_o[WIDTH-1];
  end

endmodule

// File: rtl/shift_norm_unit.sv
module shift_norm_unit
  import shift_norm_pkg::*;
#(
  parameter int WIDTH = 16,
  parameter int CW    = $clog2(WIDTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic [2:0]       op_i,
  input  logic             cnt_from_reg_i,
  input  logic [CW-1:0]    imm_cnt_i,
  input  logic [WIDTH-1:0] reg_cnt_i,
  input  logic [WIDTH-1:0] operand_i,
  output logic [WIDTH-1:0] result_o,
  output logic             zero_o,
  output logic             neg_o,
  output logic             carry_o,
  output logic             ovf_o,
  output logic             valid_o
);

  sh_op_e           op_e;
  logic [CW-1:0]    cnt;
  logic [CW-1:0]    norm_cnt;
  logic [WIDTH-1:0] core_res;
  sh_flags_t        core_flags;

  logic [WIDTH-1:0] res_d, res_q;
  sh_flags_t        flg_d, flg_q;
  logic             vld_q;

  assign op_e = sh_op_e'(op_i);

  shift_norm_cnt_sel #(.WIDTH(WIDTH), .CW(CW)) u_cnt_sel (
    .use_reg_i (cnt_from_reg_i),
    .imm_i     (imm_cnt_i),
    .reg_i     (reg_cnt_i),
    .cnt_o     (cnt)
  );

  shift_norm_lead #(.WIDTH(WIDTH), .CW(CW)) u_lead (
    .a_i   (operand_i),
    .cnt_o (norm_cnt)
  );

  shift_norm_core #(.WIDTH(WIDTH), .CW(CW)) u_core (
    .op_i    (op_e),
    .cnt_i   (cnt),
    .a_i     (operand_i),
    .norm_i  (norm_cnt),
    .res_o   (core_res),
    .flags_o (core_flags)
  );

  // Next-state: load only on a request, otherwise hold.
  always_comb begin
    res_d = res_q;
    flg_d = flg_q;
    if (req_i) begin
      res_d = core_res;
      flg_d = core_flags;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_q <= '0;
      flg_q <= '0;
      vld_q <= 1'b0;
    end else begin
      res_q <= res_d;
      flg_q <= flg_d;
      vld_q <= req_i;
    end
  end

  assign result_o = res_q;
  assign zero_o   = flg_q.z;
  assign neg_o    = flg_q.n;
  assign carry_o  = flg_q.c;
  assign ovf_o    = flg_q.v;
  assign valid_o  = vld_q;

endmodule

// File: rtl/shift_norm_chk.sv
module shift_norm_chk #(
  parameter int WIDTH = 16,
  parameter int CW    = $clog2(WIDTH)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_i,
  input logic [2:0]       op_i,
  input logic             cnt_from_reg_i,
  input logic [CW-1:0]    imm_cnt_i,
  input logic [CW-1:0]    reg_cnt_lo,
  input logic [WIDTH-1:0] operand_i,
  input logic [WIDTH-1:0] result_o,
  input logic             zero_o,
  input logic             neg_o,
  input logic             carry_o,
  input logic             ovf_o,
  input logic             valid_o
);

  logic [CW-1:0]    eff_cnt;
  logic [WIDTH-1:0] opnd_prev;
  logic [WIDTH-1:0] norm_probe;

  assign eff_cnt = cnt_from_reg_i ? reg_cnt_lo : imm_cnt_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) opnd_prev <= '0;
    else         opnd_prev <= operand_i;
  end

  assign norm_probe = opnd_prev << result_o[CW-1:0];

  assert_valid_after_req_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> valid_o);

  assert_valid_quiet_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> !valid_o);

  assert_result_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> $stable(result_o));

  assert_zero_flag_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (zero_o == (result_o == '0)));

  assert_neg_flag_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (neg_o == result_o[WIDTH-1]));

  assert_zero_dist_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && eff_cnt == '0 && op_i <= 3'd4)
      |=> (result_o == $past(operand_i) && !carry_o && !ovf_o));

  assert_no_ovf_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && (op_i == 3'd1 || op_i == 3'd2 || op_i == 3'd3 || op_i == 3'd5))
      |=> !ovf_o);

  assert_rot_keeps_bits_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && (op_i == 3'd2 || op_i == 3'd3))
      |=> ($countones(result_o) == $countones($past(operand_i))));

  assert_asr_sign_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && op_i == 3'd4) |=> (result_o[WIDTH-1] == $past(operand_i[WIDTH-1])));

  assert_norm_top_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && op_i == 3'd5 && operand_i != '0)
      |=> (norm_probe[WIDTH-1] && result_o[WIDTH-1:CW] == '0));

endmodule

bind shift_norm_unit shift_norm_chk #(.WIDTH(WIDTH), .CW(CW)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .req_i          (req_i),
  .op_i           (op_i),
  .cnt_from_reg_i (cnt_from_reg_i),
  .imm_cnt_i      (imm_cnt_i),
  .reg_cnt_lo     (reg_cnt_i[CW-1:0]),
  .operand_i      (operand_i),
  .result_o       (result_o),
  .zero_o         (zero_o),
  .neg_o          (neg_o),
  .carry_o        (carry_o),
  .ovf_o          (ovf_o),
  .valid_o        (valid_o)
);

// File: tb/shift_norm_unit_tb_top.sv
module shift_norm_unit_tb_top;

  logic        clk_i = 1'b0;
  logic        rst_ni;
  logic        req_i;
  logic [2:0]  op_i;
  logic        cnt_from_reg_i;
  logic [3:0]  imm_cnt_i;
  logic [15:0] reg_cnt_i;
  logic [15:0] operand_i;
  logic [15:0] result_o;
  logic        zero_o, neg_o, carry_o, ovf_o, valid_o;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  logic [15:0] last_res;
  logic [3:0]  last_flg;

  always #2 clk_i = ~clk_i;

  shift_norm_unit dut_i (
    .clk_i, .rst_ni, .req_i, .op_i, .cnt_from_reg_i, .imm_cnt_i,
    .reg_cnt_i, .operand_i, .result_o, .zero_o, .neg_o, .carry_o,
    .ovf_o, .valid_o
  );

  // Behavioural model: one bit position per step.
  function automatic void ref_model(input int op, input int n, input logic [15:0] a,
                                    output logic [15:0] r, output logic c, output logic v);
    logic [15:0] lost;
    int          k;
    r = a; c = 1'b0; v = 1'b0; lost = '0;
    case (op)
      0: begin
        for (int i = 0; i < n; i++) begin lost[i] = r[15]; c = r[15]; r = {r[14:0], 1'b0}; end
        for (int i = 0; i < n; i++) if (lost[i] != r[15]) v = 1'b1;
      end
      1: for (int i = 0; i < n; i++) begin c = r[0]; r = {1'b0, r[15:1]}; end
      2: for (int i = 0; i < n; i++) begin c = r[15]; r = {r[14:0], r[15]}; end
      3: for (int i = 0; i < n; i++) begin c = r[0]; r = {r[0], r[15:1]}; end
      4: for (int i = 0; i < n; i++) begin c = r[0]; if (c) v = 1'b1; r = {r[15], r[15:1]}; end
      5: begin
        k = 0;
        if (a != 0) while (!r[15]) begin r = r << 1; k++; end
        r = 16'(k);
      end
      default: r = a;
    endcase
  endfunction

  function automatic string op_tag(input int op);
    case (op)
      0: return "R1";
      1: return "R2";
      2, 3: return "R3";
      4: return "R4";
      5: return "R6";
      default: return "R12";
    endcase
  endfunction

  task automatic chk(input string tag, input string what, input logic [15:0] got,
                     input logic [15:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, got, exp);
    end
  endtask

  task automatic go(input int op, input bit sel, input logic [3:0] imm,
                    input logic [15:0] regv, input logic [15:0] a, input string tag);
    logic [15:0] r;
    logic        c, v;
    int          n;
    n = sel ? int'(regv[3:0]) : int'(imm);
    ref_model(op, n, a, r, c, v);
    req_i = 1'b1; op_i = 3'(op); cnt_from_reg_i = sel;
    imm_cnt_i = imm; reg_cnt_i = regv; operand_i = a;
    @(negedge clk_i);
    chk("R10", "valid", 16'(valid_o), 16'd1);
    chk(tag, "result", result_o, r);
    chk(tag, "carry", 16'(carry_o), 16'(c));
    chk("R5", "overflow", 16'(ovf_o), 16'(v));
    chk("R9", "zero/neg", {14'd0, zero_o, neg_o}, {14'd0, r == 16'd0, r[15]});
    last_res = r;
    last_flg = {r == 16'd0, r[15], c, v};
    req_i = 1'b0;
  endtask

  task automatic idle();
    req_i = 1'b0; operand_i = 16'($urandom); op_i = 3'($urandom);
    imm_cnt_i = 4'($urandom);
    @(negedge clk_i);
    chk("R10", "valid idle", 16'(valid_o), 16'd0);
    chk("R10", "result hold", result_o, last_res);
    chk("R10", "flags hold", {12'd0, zero_o, neg_o, carry_o, ovf_o}, {12'd0, last_flg});
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL R10 watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    logic [15:0] pats [4];
    pats[0] = 16'hA5C3; pats[1] = 16'h7FFF; pats[2] = 16'h0100; pats[3] = 16'hFFFF;
    rst_ni = 1'b0; req_i = 1'b0; op_i = '0; cnt_from_reg_i = 1'b0;
    imm_cnt_i = '0; reg_cnt_i = '0; operand_i = '0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R11", "valid after reset", 16'(valid_o), 16'd0);
    chk("R11", "result after reset", result_o, 16'd0);
    chk("R11", "flags after reset", {12'd0, zero_o, neg_o, carry_o, ovf_o}, 16'd0);
    last_res = '0; last_flg = '0;

    go(0, 0, 4, 16'h0000, 16'h8001, "R1");
    go(0, 0, 1, 16'h0000, 16'h4000, "R5");
    go(0, 0, 1, 16'h0000, 16'hC000, "R5");
    go(1, 0, 15, 16'h0000, 16'h8000, "R2");
    go(2, 0, 4, 16'h0000, 16'h1234, "R3");
    go(3, 0, 4, 16'h0000, 16'h1234, "R3");
    go(4, 0, 3, 16'h0000, 16'h8005, "R4");
    go(4, 0, 4, 16'h0000, 16'h8000, "R5");
    go(5, 0, 0, 16'h0000, 16'h0000, "R6");
    go(5, 0, 0, 16'h0000, 16'h0001, "R6");
    go(5, 0, 0, 16'h0000, 16'h8000, "R6");
    for (int op = 0; op < 5; op++) go(op, 0, 0, 16'h0000, 16'hB6D9, "R7");
    go(0, 1, 9, 16'hFFF3, 16'h0001, "R8");
    go(0, 0, 5, 16'h0007, 16'h0001, "R8");
    go(6, 0, 3, 16'h0000, 16'hABCD, "R12");
    go(7, 1, 0, 16'h0005, 16'h0000, "R12");
    idle();
    idle();

    for (int op = 0; op < 6; op++)
      for (int n = 0; n < 16; n++)
        for (int p = 0; p < 4; p++)
          go(op, n[0], 4'(n), {12'($urandom), 4'(n)}, pats[p], op_tag(op));

    for (int i = 0; i < 300; i++) begin
      int op;
      op = int'($urandom_range(0, 7));
      go(op, 1'($urandom), 4'($urandom), 16'($urandom), 16'($urandom), op_tag(op));
      if ((i % 7) == 0) idle();
    end
    idle();

    done = 1'b1;
    summary();
    $finish;
  end

endmodule